// File: doc/BRIEF.md
# RTC Alarm Repeat-Mode Matcher

This block compares a BCD time of day, supplied by an external calendar counter, against four alarm registers: seconds, minutes, hours and day of month. Each alarm register carries a "don't care" mask in bit 7. The combination of the four masks sets how often the alarm repeats: monthly, daily, hourly, once a minute or once a second. The comparison runs only on the cycle that carries the 1 Hz tick. A match sets a sticky alarm flag and, while the alarm is enabled, sends out a single-cycle interrupt pulse.

The alarm registers are loaded through a simple write port. Each write is checked against the legal BCD range of its field, and a write outside that range is dropped. A registered read port returns any alarm register, so software and the bench can observe what is stored. The flag clears when its read strobe is pulsed.

Top module: `rtc_alarm_match`

## Requirements
- R1: With all four mask bits (bit 7 of each alarm register) clear, a tick fires the alarm only when date, hours, minutes and seconds all equal the alarm values.
- R2: With only the date mask set, a tick fires the alarm when hours, minutes and seconds match, whatever the date.
- R3: With the date and hours masks set and the minutes and seconds masks clear, a tick fires when minutes and seconds match.
- R4: With the date, hours and minutes masks set and the seconds mask clear, a tick fires when seconds match.
- R5: Any other combination of mask bits makes every tick fire the alarm.
- R6: Register selects are 0 seconds, 1 minutes, 2 hours, 3 date. A seconds or minutes write needs bits 6:0 to form valid BCD from 00 to 59. An hours write needs bits 5:0 to form valid BCD from 00 to 23. A date write needs bits 5:0 to form valid BCD other than 00. The whole byte is stored on acceptance. A rejected write leaves the register unchanged.
- R7: `alarm_irq` is high for exactly one cycle, the cycle after the tick that fires the alarm.
- R8: Without `tick_1hz`, nothing fires, even when the time matches.
- R9: `alarm_irq` pulses only while `alarm_en` is high. `alarm_flag` is set by every firing tick, whatever the state of `alarm_en`.
- R10: A `flag_rd` pulse clears `alarm_flag` on the next cycle. If a firing tick arrives in the same cycle, the flag stays set.
- R11: Synchronous reset clears all four alarm registers, the flag and the interrupt.
- R12: `rd_data` shows the alarm register chosen by `rd_sel` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| wr_en | input | 1 | Alarm register write strobe |
| wr_sel | input | 2 | Register written (0 sec, 1 min, 2 hour, 3 date) |
| wr_data | input | 8 | Write value; bit 7 is the mask |
| rd_sel | input | 2 | Register returned on rd_data |
| alarm_en | input | 1 | Lets the interrupt pulse through |
| flag_rd | input | 1 | Flag read strobe; clears the flag |
| rd_data | output | 8 | Selected alarm register, registered |
| alarm_irq | output | 1 | One-cycle alarm interrupt |
| alarm_flag | output | 1 | Sticky alarm-occurred flag |

## Verification
The interrupt and the flag each pass through one register, so both are due on the cycle right after the tick. A register write takes effect at the edge that samples it. A read-back appears one cycle after `rd_sel` changes. The bench drives every input on the falling edge and samples at the next falling edge, so each result is read in exactly the cycle it is due. The interrupt is then checked again one cycle later to confirm the pulse has ended.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int BYTE_W  = 8;
  localparam int MS_W    = 7;  // seconds/minutes BCD width
  localparam int HD_W    = 6;  // hours/date BCD width
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DATE = 3;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MIN,
    RPT_SEC
  } repeat_e;

  // Range check of a candidate alarm byte for a given field index
  function automatic logic field_ok(input int idx, input logic [BYTE_W-1:0] v);
    logic ones_ok;
    ones_ok = (v[3:0] <= 4'd9);
    case (idx)
      IDX_SEC, IDX_MIN: field_ok = ones_ok && (v[6:4] <= 3'd5);
      IDX_HOUR:         field_ok = ones_ok &&
                                   ((v[5:4] < 2'd2) || (v[5:4] == 2'd2 && v[3:0] <= 4'd3));
      default:          field_ok = ones_ok && (v[5:0] != 6'd0);
    endcase
  endfunction

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import rtc_alarm_pkg::*;
#(
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 8,
  localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [SEL_W-1:0]                    wr_sel,
  input  logic [FIELD_W-1:0]                  wr_data,
  input  logic [SEL_W-1:0]                    rd_sel,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]  alm,
  output logic [FIELD_W-1:0]                  rd_data
);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i);
    logic accept;
    assign accept = wr_en && (wr_sel == MY_SEL) && field_ok(i, wr_data);

    always_ff @(posedge clk) begin
      if (rst)         alm[i] <= '0;
      else if (accept) alm[i] <= wr_data;
    end

    // R6: an out-of-range write to this field must not disturb it
    a_r6_reject_keeps: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == MY_SEL && !field_ok(i, wr_data)) |=> $stable(alm[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= alm[rd_sel];
  end

endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import rtc_alarm_pkg::*;
#(
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 8
) (
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm,
  input  logic [MS_W-1:0]                    now_sec,
  input  logic [MS_W-1:0]                    now_min,
  input  logic [HD_W-1:0]                    now_hour,
  input  logic [HD_W-1:0]                    now_date,
  output logic                               hit
);

  localparam int MASK_BIT = FIELD_W - 1;

  logic [3:0] masks;   // {date, hour, min, sec}
  logic       eq_sec, eq_min, eq_hour, eq_date;
  repeat_e    mode;

  always_comb begin
    masks = {alm[IDX_DATE][MASK_BIT], alm[IDX_HOUR][MASK_BIT],
             alm[IDX_MIN][MASK_BIT],  alm[IDX_SEC][MASK_BIT]};
    case (masks)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MIN;
      default: mode = RPT_SEC;
    endcase
  end

  always_comb begin
    eq_sec  = (alm[IDX_SEC][MS_W-1:0]  == now_sec);
    eq_min  = (alm[IDX_MIN][MS_W-1:0]  == now_min);
    eq_hour = (alm[IDX_HOUR][HD_W-1:0] == now_hour);
    eq_date = (alm[IDX_DATE][HD_W-1:0] == now_date);
    case (mode)
      RPT_MONTH: hit = eq_date && eq_hour && eq_min && eq_sec;
      RPT_DAY:   hit = eq_hour && eq_min && eq_sec;
      RPT_HOUR:  hit = eq_min && eq_sec;
      RPT_MIN:   hit = eq_sec;
      default:   hit = 1'b1;
    endcase
  end

endmodule

// File: rtl/alarm_event.sv
module alarm_event (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  input  logic enable,
  input  logic flag_clr,
  output logic irq,
  output logic flag
);

  logic fire;
  assign fire = tick && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      flag <= 1'b0;
    end else begin
      irq <= fire && enable;
      if (fire)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  // R8: a pulse only follows a tick
  a_r8_irq_after_tick: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tick));
  // R9: a pulse only while enabled
  a_r9_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(enable));
  // R9: every pulse comes with the flag
  a_r9_irq_sets_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
  // R10: a read with no concurrent firing clears the flag
  a_r10_flag_clears: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !fire) |=> !flag);
  // R10: a firing tick wins over the clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag);

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 8,
  localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_1hz,
  input  logic [MS_W-1:0]    cur_sec,
  input  logic [MS_W-1:0]    cur_min,
  input  logic [HD_W-1:0]    cur_hour,
  input  logic [HD_W-1:0]    cur_date,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic               alarm_en,
  input  logic               flag_rd,
  output logic [FIELD_W-1:0] rd_data,
  output logic               alarm_irq,
  output logic               alarm_flag
);

  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm;
  logic                               hit;

  alarm_regfile #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .alm(alm), .rd_data(rd_data)
  );

  alarm_compare #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_cmp (
    .alm(alm), .now_sec(cur_sec), .now_min(cur_min), .now_hour(cur_hour),
    .now_date(cur_date), .hit(hit)
  );

  alarm_event u_evt (
    .clk(clk), .rst(rst), .tick(tick_1hz), .hit(hit), .enable(alarm_en),
    .flag_clr(flag_rd), .irq(alarm_irq), .flag(alarm_flag)
  );

endmodule

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic [6:0] cur_sec = '0, cur_min = '0;
  logic [5:0] cur_hour = '0, cur_date = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0;
  logic       alarm_en = 1'b0, flag_rd = 1'b0;
  logic [7:0] rd_data;
  logic       alarm_irq, alarm_flag;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_match uut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .alarm_en(alarm_en), .flag_rd(flag_rd), .rd_data(rd_data),
    .alarm_irq(alarm_irq), .alarm_flag(alarm_flag)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_sel = sel;
    @(negedge clk); chk(rd_data, exp, tag);
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  // Tick at a given time; check the pulse the cycle after, and its end
  task automatic tick_chk(input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [5:0] d,
                          input logic exp, input string tag);
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    chk({7'd0, alarm_irq}, {7'd0, exp}, tag);
    @(negedge clk);
    chk({7'd0, alarm_irq}, 8'd0, {tag, " R7 pulse ends"});
  endtask

  task automatic t_reset();
    chk({7'd0, alarm_irq}, 8'd0, "R11 irq after reset");
    chk({7'd0, alarm_flag}, 8'd0, "R11 flag after reset");
    for (int i = 0; i < 4; i++) rd_chk(2'(i), 8'h00, "R11 R12 reg zero after reset");
  endtask

  task automatic t_monthly();
    wr(0, 8'h30); wr(1, 8'h15); wr(2, 8'h12); wr(3, 8'h07);
    alarm_en = 1'b1;
    rd_chk(2, 8'h12, "R12 readback hours");
    tick_chk(7'h30, 7'h15, 6'h12, 6'h07, 1'b1, "R1 full match");
    chk({7'd0, alarm_flag}, 8'd1, "R9 flag set on match");
    tick_chk(7'h30, 7'h15, 6'h12, 6'h08, 1'b0, "R1 date differs");
    tick_chk(7'h31, 7'h15, 6'h12, 6'h07, 1'b0, "R1 seconds differ");
  endtask

  task automatic t_daily();
    wr(3, 8'h87);
    tick_chk(7'h30, 7'h15, 6'h12, 6'h09, 1'b1, "R2 any date");
    tick_chk(7'h30, 7'h15, 6'h13, 6'h09, 1'b0, "R2 hour differs");
  endtask

  task automatic t_hourly();
    wr(2, 8'h92);
    tick_chk(7'h30, 7'h15, 6'h05, 6'h21, 1'b1, "R3 any hour");
    tick_chk(7'h30, 7'h16, 6'h05, 6'h21, 1'b0, "R3 minute differs");
  endtask

  task automatic t_minute();
    wr(1, 8'h95);
    tick_chk(7'h30, 7'h44, 6'h08, 6'h03, 1'b1, "R4 any minute");
    tick_chk(7'h31, 7'h44, 6'h08, 6'h03, 1'b0, "R4 second differs");
  endtask

  task automatic t_per_second();
    wr(0, 8'hB0);
    tick_chk(7'h01, 7'h02, 6'h03, 6'h04, 1'b1, "R5 all masks");
    wr(3, 8'h07); wr(2, 8'h12); wr(1, 8'h15); wr(0, 8'h80);
    tick_chk(7'h00, 7'h00, 6'h00, 6'h01, 1'b1, "R5 seconds mask only");
    wr(3, 8'h87); wr(1, 8'h95); wr(0, 8'h30);
    tick_chk(7'h45, 7'h00, 6'h00, 6'h01, 1'b1, "R5 date+minute masks");
  endtask

  task automatic t_limits();
    // state: sec 30, min 95, hour 12, date 87
    wr(0, 8'h60); rd_chk(0, 8'h30, "R6 sec 60 rejected");
    wr(0, 8'h3A); rd_chk(0, 8'h30, "R6 sec bad digit rejected");
    wr(1, 8'h60); rd_chk(1, 8'h95, "R6 min 60 rejected");
    wr(2, 8'h24); rd_chk(2, 8'h12, "R6 hour 24 rejected");
    wr(2, 8'h1A); rd_chk(2, 8'h12, "R6 hour bad digit rejected");
    wr(3, 8'h00); rd_chk(3, 8'h87, "R6 date 00 rejected");
    wr(3, 8'hC0); rd_chk(3, 8'h87, "R6 date masked 00 rejected");
    wr(0, 8'h59); rd_chk(0, 8'h59, "R6 sec 59 accepted");
    wr(1, 8'hD9); rd_chk(1, 8'hD9, "R6 min 59 with mask accepted");
    wr(2, 8'h23); rd_chk(2, 8'h23, "R6 hour 23 accepted");
    wr(3, 8'h31); rd_chk(3, 8'h31, "R6 date 31 accepted");
  endtask

  task automatic t_no_tick();
    // masks now {0,0,1,0}: per-second mode, any tick would fire
    @(negedge clk); cur_sec = 7'h59; cur_min = 7'h59; cur_hour = 6'h23; cur_date = 6'h31;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk({7'd0, alarm_irq}, 8'd0, "R8 no tick no pulse");
    end
  endtask

  task automatic t_enable_flag();
    clear_flag();
    chk({7'd0, alarm_flag}, 8'd0, "R10 flag cleared by read");
    alarm_en = 1'b0;
    tick_chk(7'h10, 7'h10, 6'h10, 6'h10, 1'b0, "R9 disabled no pulse");
    chk({7'd0, alarm_flag}, 8'd1, "R9 flag set while disabled");
    @(negedge clk); tick_1hz = 1'b1; flag_rd = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; flag_rd = 1'b0;
    chk({7'd0, alarm_flag}, 8'd1, "R10 firing wins over read");
    clear_flag();
    chk({7'd0, alarm_flag}, 8'd0, "R10 flag cleared again");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_monthly();
    t_daily();
    t_hourly();
    t_minute();
    t_per_second();
    t_limits();
    t_no_tick();
    t_enable_flag();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule